// File: doc/BRIEF.md
# NVM Status Polling Sequencer

This block drives a byte-wide serial transceiver to find out whether a target device is ready for non-volatile memory work. It runs one of two polling loops. The first loop is the access-enable poll. It sends a single control/status load byte aimed at the status register and reads one byte back. It stops with success as soon as the enable flag in that byte is set. After a fixed number of unsuccessful reads it stops with failure.

The second loop is the controller-busy poll. It sends a one-byte direct-load command followed by a four-byte address, then reads one byte. It repeats this whole sequence until bit 7 of the returned byte is clear. This loop has no attempt limit.

The caller pulses one of the two start inputs. It then waits for a single-cycle done pulse, and the success flag is valid in that same cycle. Toward the transceiver the block offers a valid/ready transmit port and a ready/valid receive port, and it never has both active at once. Opcodes, base addresses, flag position and attempt limit are parameters.

Top module: `nvm_poll_seq`

## Requirements
- R1: While reset is asserted, and until the first start, `done_o`, `ok_o`, `tx_valid_o` and `rx_ready_o` are 0.
- R2: The access-enable poll sends exactly one byte per attempt, equal to `CS_OP | STAT_IDX` (0x80 with default parameters), then reads one byte.
- R3: The access-enable poll ends with `ok_o`=1 on the first returned byte whose bit `EN_BIT` (bit 1 by default) is 1. No further byte is sent after it.
- R4: The access-enable poll ends with `ok_o`=0 after `MAX_TRIES` (255) returned bytes all had bit `EN_BIT` clear. No further byte is sent or read after that.
- R5: The controller-busy poll sends, per attempt, the byte `LD_OP | (SIZE_CODE << 2)` (0x00 by default). It follows this with the four bytes of `DATA_BASE + NVMC_BASE + REG_OFS`, most significant first (0x01, 0x00, 0x01, 0xCF by default), then reads one byte.
- R6: The controller-busy poll ends with `ok_o`=1 on the first returned byte whose bit `BUSY_BIT` (bit 7) is 0. Otherwise it repeats the full five-byte sequence with no attempt limit.
- R7: A byte is taken by the transceiver only in a cycle with `tx_valid_o` and `tx_ready_i` both 1. While `tx_valid_o`=1 and `tx_ready_i`=0, `tx_byte_o` and `tx_valid_o` hold. A reply is consumed only when `rx_valid_i` and `rx_ready_o` are both 1, and `tx_valid_o` and `rx_ready_o` are never 1 together.
- R8: `done_o` is a one-cycle pulse, one clock after the final reply is consumed. `ok_o` carries the result in that cycle and is 0 whenever `done_o` is 0.
- R9: Start inputs are ignored while a poll is in progress. The byte stream, read count and result are those of the poll already running, and the block is idle once `done_o` is seen.
- R10: When both start inputs are 1 in the same idle cycle, the access-enable poll is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_enable_i | input | 1 | Start the access-enable poll |
| start_busy_i | input | 1 | Start the controller-busy poll |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Poll result, valid with done_o |
| tx_valid_o | output | 1 | Command byte offered to the transceiver |
| tx_ready_i | input | 1 | Transceiver accepts the offered byte |
| tx_byte_o | output | 8 | Command byte |
| rx_ready_o | output | 1 | Sequencer waits for a reply byte |
| rx_valid_i | input | 1 | Reply byte present |
| rx_byte_i | input | 8 | Reply byte |

## Verification
A corrupted byte index or poll kind appears within one attempt as a wrong byte in the transmit stream, so every byte of every attempt is compared against the expected command sequence. A faulty attempt counter shows only at the end of a long failing enable poll, as a wrong read count or result. For that reason, runs of exactly the limit, one short of it, and a busy poll longer than the limit are driven. A lost hold on a stalled transmit byte is visible in the cycle after the stall. Random ready/valid gaps, together with start noise during polls, expose any dependence on handshake timing.

// File: rtl/nvm_poll_pkg.sv
package nvm_poll_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } seq_state_e;

  typedef enum logic {
    POLL_ENABLE = 1'b0,
    POLL_BUSY   = 1'b1
  } poll_kind_e;

  localparam int unsigned ADDR_BYTES = 4;
  localparam int unsigned AB_W       = $clog2(ADDR_BYTES);
  localparam int unsigned IDX_W      = $clog2(ADDR_BYTES + 1);

endpackage

// File: rtl/nvm_poll_rstsync.sv
module nvm_poll_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nvm_poll_cmd.sv
module nvm_poll_cmd
  import nvm_poll_pkg::*;
#(
  parameter logic [7:0]  CS_OP     = 8'h80,
  parameter logic [3:0]  STAT_IDX  = 4'h0,
  parameter logic [7:0]  LD_OP     = 8'h00,
  parameter logic [1:0]  SIZE_CODE = 2'b00,
  parameter logic [31:0] DATA_BASE = 32'h0100_0000,
  parameter logic [31:0] NVMC_BASE = 32'h0000_01C0,
  parameter logic [7:0]  REG_OFS   = 8'h0F
) (
  input  poll_kind_e       kind_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       cmd_byte_o,
  output logic             last_o
);

  localparam logic [31:0] TARGET_ADDR = DATA_BASE + NVMC_BASE + {24'd0, REG_OFS};
  localparam logic [7:0]  ENA_CMD     = CS_OP | {4'd0, STAT_IDX};
  localparam logic [7:0]  LOAD_CMD    = LD_OP | {4'd0, SIZE_CODE, 2'b00};

  logic [7:0]       addr_b [ADDR_BYTES];
  logic [IDX_W-1:0] sel;

  // byte 0 of the address phase is the most significant one
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_b[g] = TARGET_ADDR[8*(ADDR_BYTES-1-g) +: 8];
  end

  assign sel = idx_i - 1'b1;

  always_comb begin
    if (kind_i == POLL_ENABLE) begin
      cmd_byte_o = ENA_CMD;
      last_o     = 1'b1;
    end else begin
      if (idx_i == '0) begin
        cmd_byte_o = LOAD_CMD;
      end else begin
        cmd_byte_o = addr_b[sel[AB_W-1:0]];
      end
      last_o = (idx_i == IDX_W'(ADDR_BYTES));
    end
  end

endmodule

// File: rtl/nvm_poll_tries.sv
module nvm_poll_tries #(
  parameter int unsigned MAX_TRIES = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // failures already counted equal limit minus one: current read is the last
  assign last_o = (cnt_q == CW'(MAX_TRIES - 1));

endmodule

// File: rtl/nvm_poll_seq.sv
module nvm_poll_seq
  import nvm_poll_pkg::*;
#(
  parameter logic [7:0]  CS_OP     = 8'h80,
  parameter logic [3:0]  STAT_IDX  = 4'h0,
  parameter logic [7:0]  LD_OP     = 8'h00,
  parameter logic [1:0]  SIZE_CODE = 2'b00,
  parameter logic [31:0] DATA_BASE = 32'h0100_0000,
  parameter logic [31:0] NVMC_BASE = 32'h0000_01C0,
  parameter logic [7:0]  REG_OFS   = 8'h0F,
  parameter int unsigned EN_BIT    = 1,
  parameter int unsigned BUSY_BIT  = 7,
  parameter int unsigned MAX_TRIES = 255,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_enable_i,
  input  logic       start_busy_i,
  output logic       done_o,
  output logic       ok_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i,
  output logic [7:0] tx_byte_o,
  output logic       rx_ready_o,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i
);

  logic             rst_int_n;
  seq_state_e       state_q, state_d;
  poll_kind_e       kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             ok_q, ok_d;
  logic             ctl_en;
  logic             cmd_last;
  logic             tries_clr, tries_inc, tries_last;
  logic [7:0]       cmd_byte;

  nvm_poll_rstsync #(.STAGES(SYNC_STG)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  nvm_poll_cmd #(
    .CS_OP     (CS_OP),
    .STAT_IDX  (STAT_IDX),
    .LD_OP     (LD_OP),
    .SIZE_CODE (SIZE_CODE),
    .DATA_BASE (DATA_BASE),
    .NVMC_BASE (NVMC_BASE),
    .REG_OFS   (REG_OFS)
  ) u_cmd (
    .kind_i     (kind_q),
    .idx_i      (idx_q),
    .cmd_byte_o (cmd_byte),
    .last_o     (cmd_last)
  );

  nvm_poll_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (tries_clr),
    .inc_i  (tries_inc),
    .last_o (tries_last)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    idx_d     = idx_q;
    done_d    = 1'b0;
    ok_d      = 1'b0;
    tries_clr = 1'b0;
    tries_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_enable_i || start_busy_i) begin
          kind_d    = start_enable_i ? POLL_ENABLE : POLL_BUSY;
          idx_d     = '0;
          tries_clr = 1'b1;
          state_d   = ST_SEND;
        end
      end
      ST_SEND: begin
        if (tx_ready_i) begin
          if (cmd_last) begin
            idx_d   = '0;
            state_d = ST_RECV;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RECV: begin
        if (rx_valid_i) begin
          if (kind_q == POLL_ENABLE) begin
            if (rx_byte_i[EN_BIT]) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              ok_d    = 1'b1;
            end else if (tries_last) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              tries_inc = 1'b1;
              state_d   = ST_SEND;
            end
          end else begin
            if (!rx_byte_i[BUSY_BIT]) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              ok_d    = 1'b1;
            end else begin
              state_d = ST_SEND;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_q != ST_IDLE) || start_enable_i || start_busy_i;

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      kind_q  <= POLL_ENABLE;
      idx_q   <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      kind_q  <= kind_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      ok_q   <= ok_d;
    end
  end

  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign tx_valid_o = (state_q == ST_SEND);
  assign rx_ready_o = (state_q == ST_RECV);
  assign tx_byte_o  = cmd_byte;

endmodule

// File: rtl/nvm_poll_seq_chk.sv
module nvm_poll_seq_chk
  import nvm_poll_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 255
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done_o,
  input logic       ok_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [7:0] tx_byte_o,
  input logic       rx_ready_o,
  input logic       rx_valid_i,
  input poll_kind_e kind_q
);

  localparam int unsigned RW = $clog2(MAX_TRIES + 2);

  logic [RW-1:0] reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reads_q <= '0;
    end else if (done_o) begin
      reads_q <= '0;
    end else if (rx_valid_i && rx_ready_o && kind_q == POLL_ENABLE) begin
      reads_q <= reads_q + 1'b1;
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_ok_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !ok_o);

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid_o && rx_ready_o));

  p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!tx_valid_o && !rx_ready_o));

  p_read_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= RW'(MAX_TRIES));

endmodule

bind nvm_poll_seq nvm_poll_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_o     (done_o),
  .ok_o       (ok_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_byte_o  (tx_byte_o),
  .rx_ready_o (rx_ready_o),
  .rx_valid_i (rx_valid_i),
  .kind_q     (kind_q)
);

// File: tb/nvm_poll_seq_bench.sv
module nvm_poll_seq_bench;

  localparam logic [7:0]  B_CS_OP   = 8'h80;
  localparam logic [3:0]  B_STAT    = 4'h0;
  localparam logic [7:0]  B_LD_OP   = 8'h00;
  localparam logic [1:0]  B_SIZE    = 2'b00;
  localparam logic [31:0] B_DBASE   = 32'h0100_0000;
  localparam logic [31:0] B_NBASE   = 32'h0000_01C0;
  localparam logic [7:0]  B_OFS     = 8'h0F;
  localparam int          B_EN      = 1;
  localparam int          B_BUSY    = 7;
  localparam int          B_MAX     = 255;
  localparam int          RESP_N    = 320;
  localparam int          LOG_N     = 2000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_enable_i, start_busy_i;
  logic       done_o, ok_o, tx_valid_o, tx_ready_i, rx_ready_o, rx_valid_i;
  logic [7:0] tx_byte_o, rx_byte_i;

  int         errors = 0;
  int         checks = 0;
  logic [7:0] resp [RESP_N];
  int         resp_n = 0;
  int         resp_ptr = 0;
  logic [7:0] tx_log [LOG_N];
  int         tx_cnt = 0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_byte = 8'h00;
  bit         resp_on = 1'b0;

  always #2.5 clk = ~clk;

  nvm_poll_seq #(
    .CS_OP(B_CS_OP), .STAT_IDX(B_STAT), .LD_OP(B_LD_OP), .SIZE_CODE(B_SIZE),
    .DATA_BASE(B_DBASE), .NVMC_BASE(B_NBASE), .REG_OFS(B_OFS),
    .EN_BIT(B_EN), .BUSY_BIT(B_BUSY), .MAX_TRIES(B_MAX)
  ) u_nvm_poll_seq (
    .clk(clk), .rst_n(rst_n),
    .start_enable_i(start_enable_i), .start_busy_i(start_busy_i),
    .done_o(done_o), .ok_o(ok_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_byte_o(tx_byte_o),
    .rx_ready_o(rx_ready_o), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i)
  );

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input bit busy, input int j);
    logic [31:0] a;
    a = B_DBASE + B_NBASE + {24'd0, B_OFS};
    if (!busy) return B_CS_OP | {4'd0, B_STAT};
    if (j == 0) return B_LD_OP | {4'd0, B_SIZE, 2'b00};
    return a[8*(4-j) +: 8];
  endfunction

  // transceiver model: drives at the falling edge, records a transfer
  // that the next rising edge will complete
  always @(negedge clk) begin
    tx_ready_i = ($urandom % 4) != 0;
    rx_valid_i = 1'b0;
    if (resp_on && rx_ready_o && (($urandom % 3) != 0) && resp_ptr < resp_n) begin
      rx_valid_i = 1'b1;
      rx_byte_i  = resp[resp_ptr];
    end
    #1;
    if (prev_stall)
      chk(tx_valid_o && tx_byte_o == prev_byte, "R7", "stalled byte held",
          tx_byte_o, prev_byte);
    prev_stall = tx_valid_o && !tx_ready_i;
    prev_byte  = tx_byte_o;
    if (tx_valid_o && rx_ready_o)
      chk(1'b0, "R7", "tx and rx active together", 1, 0);
    if (tx_valid_o && tx_ready_i && tx_cnt < LOG_N) begin
      tx_log[tx_cnt] = tx_byte_o;
      tx_cnt++;
    end
    if (rx_valid_i && rx_ready_o) resp_ptr++;
  end

  task automatic run_poll(input bit en, input bit bz, input bit noise, input string req);
    bit   busy_kind;
    int   exp_reads, seq_len, waited;
    bit   exp_ok;
    logic got_ok;
    busy_kind = !en;
    seq_len   = busy_kind ? 5 : 1;
    exp_reads = resp_n;
    exp_ok    = 1'b0;
    for (int i = 0; i < resp_n; i++) begin
      if (!busy_kind && resp[i][B_EN]) begin exp_reads = i + 1; exp_ok = 1'b1; break; end
      if (!busy_kind && i + 1 == B_MAX) begin exp_reads = B_MAX; exp_ok = 1'b0; break; end
      if (busy_kind && !resp[i][B_BUSY]) begin exp_reads = i + 1; exp_ok = 1'b1; break; end
    end
    tx_cnt   = 0;
    resp_ptr = 0;
    resp_on  = 1'b1;
    @(negedge clk);
    start_enable_i = en;
    start_busy_i   = bz;
    @(negedge clk);
    start_enable_i = 1'b0;
    start_busy_i   = 1'b0;
    waited = 0;
    while (!done_o && waited < 20000) begin
      if (noise) begin
        start_enable_i = $urandom % 2;
        start_busy_i   = $urandom % 2;
      end
      @(negedge clk);
      waited++;
    end
    start_enable_i = 1'b0;
    start_busy_i   = 1'b0;
    chk(done_o == 1'b1, req, "done seen", done_o, 1);
    got_ok = ok_o;
    chk(got_ok == exp_ok, req, "result", got_ok, exp_ok);
    chk(resp_ptr == exp_reads, req, "reply count", resp_ptr, exp_reads);
    chk(tx_cnt == exp_reads * seq_len, req, "byte count", tx_cnt, exp_reads * seq_len);
    for (int j = 0; j < tx_cnt; j++) begin
      if (tx_log[j] != exp_cmd(busy_kind, j % seq_len)) begin
        chk(1'b0, req, $sformatf("byte %0d", j), tx_log[j], exp_cmd(busy_kind, j % seq_len));
        break;
      end
    end
    checks++;
    @(negedge clk);
    chk(done_o == 1'b0 && ok_o == 1'b0, "R8", "done one cycle, ok gated", {done_o, ok_o}, 0);
    chk(!tx_valid_o && !rx_ready_o, "R9", "idle after done", {tx_valid_o, rx_ready_o}, 0);
    resp_on = 1'b0;
  endtask

  function automatic logic [7:0] fail_byte(input bit busy);
    logic [7:0] v;
    v = $urandom;
    if (busy) v[B_BUSY] = 1'b1; else v[B_EN] = 1'b0;
    return v;
  endfunction

  function automatic logic [7:0] pass_byte(input bit busy);
    logic [7:0] v;
    v = $urandom;
    if (busy) v[B_BUSY] = 1'b0; else v[B_EN] = 1'b1;
    return v;
  endfunction

  task automatic fill(input bit busy, input int nfail, input int total);
    for (int i = 0; i < total; i++)
      resp[i] = (i < nfail) ? fail_byte(busy) : pass_byte(busy);
    resp_n = total;
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    start_enable_i = 1'b0;
    start_busy_i   = 1'b0;
    rx_byte_i      = 8'h00;
    repeat (3) @(negedge clk);
    chk(!done_o && !ok_o && !tx_valid_o && !rx_ready_o, "R1", "outputs in reset",
        {done_o, ok_o, tx_valid_o, rx_ready_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done_o && !ok_o && !tx_valid_o && !rx_ready_o, "R1", "outputs after release",
        {done_o, ok_o, tx_valid_o, rx_ready_o}, 0);

    fill(1'b0, 0, 4);   run_poll(1'b1, 1'b0, 1'b0, "R2");
    fill(1'b0, 3, 6);   run_poll(1'b1, 1'b0, 1'b0, "R3");
    fill(1'b0, 254, 260); run_poll(1'b1, 1'b0, 1'b0, "R3");
    fill(1'b0, 300, 300); run_poll(1'b1, 1'b0, 1'b0, "R4");
    fill(1'b1, 0, 2);   run_poll(1'b0, 1'b1, 1'b0, "R5");
    fill(1'b1, 300, 302); run_poll(1'b0, 1'b1, 1'b0, "R6");
    fill(1'b0, 2, 4);   run_poll(1'b1, 1'b1, 1'b0, "R10");
    fill(1'b1, 6, 8);   run_poll(1'b0, 1'b1, 1'b1, "R9");
    fill(1'b0, 5, 8);   run_poll(1'b1, 1'b0, 1'b1, "R9");

    for (int k = 0; k < 20; k++) begin
      bit busy;
      int nf;
      busy = $urandom % 2;
      nf   = $urandom % 12;
      fill(busy, nf, nf + 3);
      run_poll(!busy, busy, ($urandom % 2) == 1, busy ? "R6" : "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule